// File: doc/BRIEF.md
# Multi-Axis Quadrature Counter with Last-Edge Time Capture

This block decodes the two-phase signals of several incremental encoders and keeps a signed-free 24-bit position per axis. Alongside the position, every axis records the value of a shared, free-running time counter at the moment its most recent step was accepted. Servo software can then estimate velocity from both the step count and the precise edge time, instead of from coarse counts alone.

The count and the captured time always describe the same step. Each axis packs its low count bits and the captured time into one 32-bit word, and both halves are loaded in one clock cycle. A sample strobe copies the packed words, the full positions and the error flags of every axis into read-side shadow registers in one cycle. Host reads through a small select port therefore see one consistent picture across all axes, however long the read sequence takes.

Top module: `qstamp_top`

## Requirements
- R1: After reset, every read selection of every axis returns zero, and the time counter starts at zero.
- R2: With the phase pair written as {A,B}, the sequence 00, 10, 11, 01, 00 (A leading) adds one to the axis position for each step.
- R3: The reverse sequence 00, 01, 11, 10, 00 subtracts one per step, and the 24-bit position wraps modulo 2^24 (one step down from zero gives 0xFFFFFF).
- R4: A change of both A and B in one synchronized sample leaves the position and the packed word unchanged and sets a per-axis error flag that stays set until reset; later legal steps are still counted.
- R5: The shared time counter advances by one on every clock where the tick enable is high, holds otherwise, and wraps modulo 2^16 with the default split.
- R6: An encoder input change is accepted on the third rising clock edge after it is applied; on that edge the packed word loads the new position's low 16 bits into bits 31:16 and the current time value into bits 15:0.
- R7: The packed word holds the time of the latest accepted step only, not of any earlier step since the last sample.
- R8: A sample strobe copies all axes' packed words, positions and error flags at once; reads return those copies unchanged until the next strobe, whatever the encoders do meanwhile.
- R9: The read select chooses the view: 00 returns the packed word, 01 the 24-bit position zero-extended to 32 bits, 10 the error flag in bit 0, and 11 returns zero.
- R10: Steps on one axis do not alter the position, packed word or error flag of any other axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | NUM_AXES | Phase A of each encoder, asynchronous |
| enc_b | input | NUM_AXES | Phase B of each encoder, asynchronous |
| ts_tick | input | 1 | Time counter advance enable |
| sample_stb | input | 1 | Copies all axes into the read shadow |
| rd_axis | input | AXIS_IDX_W | Axis chosen for reading |
| rd_sel | input | 2 | View chosen for reading (see R9) |
| rd_data | output | 32 | Read data from the shadow registers |

## Verification
An encoder change applied between clock edges passes two synchronizer flops and is counted on the third rising edge, so the bench waits four clocks after each phase change before it strobes a sample. The shadow registers load on the strobe edge and the read path is combinational from them, so the bench sets the read select after the strobe and samples one time unit later, well clear of the next edge. The time counter is only enabled during explicit tick windows that never overlap an encoder change, which makes the expected captured time the exact number of ticks driven so far, taken modulo 2^16.

// File: rtl/qstamp_pkg.sv
package qstamp_pkg;

   typedef enum logic [1:0] {
      VIEW_WORD = 2'b00,
      VIEW_POS  = 2'b01,
      VIEW_ERR  = 2'b10,
      VIEW_NONE = 2'b11
   } view_e;

   typedef enum logic [1:0] {
      MV_NONE = 2'b00,
      MV_UP   = 2'b01,
      MV_DOWN = 2'b10,
      MV_BAD  = 2'b11
   } move_e;

   // Classify one synchronized sample pair {A,B} against the previous one.
   function automatic move_e classify(input logic [1:0] prev, input logic [1:0] cur);
      move_e m;
      case ({prev, cur})
         4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: m = MV_UP;
         4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: m = MV_DOWN;
         4'b00_11, 4'b11_00, 4'b01_10, 4'b10_01: m = MV_BAD;
         default:                                m = MV_NONE;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/qstamp_sync.sv
module qstamp_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             vld
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qstamp_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0]  pipe [STAGES];
   logic [STAGES-1:0] fill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
         fill <= '0;
      end else begin
         pipe[0] <= din;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         fill <= {fill[STAGES-2:0], 1'b1};
      end
   end

   assign dout = pipe[STAGES-1];
   assign vld  = fill[STAGES-1];

endmodule

// File: rtl/qstamp_decode.sv
module qstamp_decode
   import qstamp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ab,
   input  logic       ab_vld,
   output move_e      move
);

   logic [1:0] prev_ab;
   logic       prev_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_ab  <= 2'b00;
         prev_vld <= 1'b0;
      end else begin
         prev_ab  <= ab;
         prev_vld <= ab_vld;
      end
   end

   assign move = prev_vld ? classify(prev_ab, ab) : MV_NONE;

   // A reported step must match a real change between consecutive samples.
   AST_STEP_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (move != MV_NONE) |-> (ab != prev_ab)); // R4

endmodule

// File: rtl/qstamp_axis.sv
module qstamp_axis
   import qstamp_pkg::*;
#(
   parameter int POS_W = 24,
   parameter int CNT_W = 16,
   parameter int TS_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  move_e                 move,
   input  logic [TS_W-1:0]       ts_now,
   output logic [POS_W-1:0]      pos,
   output logic [CNT_W+TS_W-1:0] word,
   output logic                  err
);

   generate
      if (CNT_W > POS_W) begin : g_bad_cnt
         $error("count field wider than position counter");
      end
   endgenerate

   logic [POS_W-1:0] pos_nxt;
   logic             take;

   always_comb begin
      pos_nxt = pos;
      take    = 1'b0;
      case (move)
         MV_UP:   begin pos_nxt = pos + 1'b1; take = 1'b1; end
         MV_DOWN: begin pos_nxt = pos - 1'b1; take = 1'b1; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos  <= '0;
         word <= '0;
         err  <= 1'b0;
      end else begin
         pos <= pos_nxt;
         if (take) word <= {pos_nxt[CNT_W-1:0], ts_now};
         if (move == MV_BAD) err <= 1'b1;
      end
   end

   AST_UP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (move == MV_UP) |=> (pos == $past(pos) + 1'b1)); // R2
   AST_DOWN_SUBS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (move == MV_DOWN) |=> (pos == $past(pos) - 1'b1)); // R3
   AST_BAD_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (move == MV_BAD) |=> ($stable(pos) && $stable(word))); // R4
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err); // R4
   AST_PAIR_SAME_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((move == MV_UP) || (move == MV_DOWN)) |=>
      ((word[CNT_W+TS_W-1:TS_W] == pos[CNT_W-1:0]) && (word[TS_W-1:0] == $past(ts_now)))); // R6

endmodule

// File: rtl/qstamp_top.sv
module qstamp_top
   import qstamp_pkg::*;
#(
   parameter int NUM_AXES    = 4,
   parameter int POS_W       = 24,
   parameter int WORD_W      = 32,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int TS_W       = WORD_W - CNT_W,
   localparam int AXIS_IDX_W = (NUM_AXES > 1) ? $clog2(NUM_AXES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_AXES-1:0]   enc_a,
   input  logic [NUM_AXES-1:0]   enc_b,
   input  logic                  ts_tick,
   input  logic                  sample_stb,
   input  logic [AXIS_IDX_W-1:0] rd_axis,
   input  logic [1:0]            rd_sel,
   output logic [WORD_W-1:0]     rd_data
);

   generate
      if (NUM_AXES < 1) begin : g_bad_axes
         $error("at least one axis is required");
      end
      if (CNT_W < 2 || CNT_W >= WORD_W) begin : g_bad_split
         $error("count field must leave room for the time field");
      end
      if (POS_W > WORD_W) begin : g_bad_pos
         $error("position must fit one read word");
      end
   endgenerate

   // Shared time base
   logic [TS_W-1:0] ts_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)       ts_cnt <= '0;
      else if (ts_tick) ts_cnt <= ts_cnt + 1'b1;
   end

   AST_TS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ts_tick |=> $stable(ts_cnt)); // R5
   AST_TS_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      ts_tick |=> (ts_cnt == TS_W'($past(ts_cnt) + 1'b1))); // R5

   // Input synchronizer, pairs packed as {A,B} per axis
   logic [2*NUM_AXES-1:0] raw_ab;
   logic [2*NUM_AXES-1:0] sync_ab;
   logic                  sync_vld;

   always_comb begin
      for (int i = 0; i < NUM_AXES; i++) begin
         raw_ab[2*i+1] = enc_a[i];
         raw_ab[2*i]   = enc_b[i];
      end
   end

   qstamp_sync #(.WIDTH(2*NUM_AXES), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_ab),
      .dout (sync_ab),
      .vld  (sync_vld)
   );

   // Per-axis decode, count and capture
   logic [POS_W-1:0]  ax_pos  [NUM_AXES];
   logic [WORD_W-1:0] ax_word [NUM_AXES];
   logic [NUM_AXES-1:0] ax_err;

   logic [POS_W-1:0]  sh_pos  [NUM_AXES];
   logic [WORD_W-1:0] sh_word [NUM_AXES];
   logic [NUM_AXES-1:0] sh_err;

   generate
      for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
         move_e mv;

         qstamp_decode u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .ab    (sync_ab[2*g+1:2*g]),
            .ab_vld(sync_vld),
            .move  (mv)
         );

         qstamp_axis #(.POS_W(POS_W), .CNT_W(CNT_W), .TS_W(TS_W)) u_axis (
            .clk   (clk),
            .rst_n (rst_n),
            .move  (mv),
            .ts_now(ts_cnt),
            .pos   (ax_pos[g]),
            .word  (ax_word[g]),
            .err   (ax_err[g])
         );

         AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !sample_stb |=> ($stable(sh_word[g]) && $stable(sh_pos[g]) && $stable(sh_err[g]))); // R8
         AST_SHADOW_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
            sample_stb |=> ((sh_word[g] == $past(ax_word[g])) && (sh_pos[g] == $past(ax_pos[g])))); // R8
      end
   endgenerate

   // Read-side snapshot of all axes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_AXES; i++) begin
            sh_pos[i]  <= '0;
            sh_word[i] <= '0;
         end
         sh_err <= '0;
      end else if (sample_stb) begin
         for (int i = 0; i < NUM_AXES; i++) begin
            sh_pos[i]  <= ax_pos[i];
            sh_word[i] <= ax_word[i];
         end
         sh_err <= ax_err;
      end
   end

   // Read view selection
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_AXES; i++) begin
         if (int'(rd_axis) == i) begin
            case (view_e'(rd_sel))
               VIEW_WORD: rd_data = sh_word[i];
               VIEW_POS:  rd_data = WORD_W'(sh_pos[i]);
               VIEW_ERR:  rd_data = WORD_W'(sh_err[i]);
               default:   rd_data = '0;
            endcase
         end
      end
   end

endmodule

// File: tb/tb_qstamp_top.sv
module tb_qstamp_top;

   localparam int NA = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NA-1:0] enc_a = '0;
   logic [NA-1:0] enc_b = '0;
   logic        ts_tick = 1'b0;
   logic        sample_stb = 1'b0;
   logic [1:0]  rd_axis = '0;
   logic [1:0]  rd_sel = '0;
   logic [31:0] rd_data;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [23:0] exp_pos [NA];
   logic [31:0] exp_word [NA];
   logic        exp_err [NA];
   logic [1:0]  ab_now  [NA];
   logic [15:0] exp_ts;

   always #5 clk = ~clk;

   qstamp_top dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .enc_a     (enc_a),
      .enc_b     (enc_b),
      .ts_tick   (ts_tick),
      .sample_stb(sample_stb),
      .rd_axis   (rd_axis),
      .rd_sel    (rd_sel),
      .rd_data   (rd_data)
   );

   task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
      end
   endtask

   task automatic read(input int ax, input logic [1:0] sel, output logic [31:0] val);
      @(negedge clk);
      rd_axis = 2'(ax);
      rd_sel  = sel;
      #1;
      val = rd_data;
   endtask

   task automatic strobe();
      @(negedge clk);
      sample_stb = 1'b1;
      @(negedge clk);
      sample_stb = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      ts_tick = 1'b1;
      repeat (n) @(negedge clk);
      ts_tick = 1'b0;
      exp_ts = 16'(exp_ts + 16'(n));
   endtask

   task automatic set_ab(input int ax, input logic [1:0] v);
      @(negedge clk);
      enc_a[ax] = v[1];
      enc_b[ax] = v[0];
      ab_now[ax] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic step(input int ax, input bit up);
      logic [1:0] nx;
      case (ab_now[ax])
         2'b00: nx = up ? 2'b10 : 2'b01;
         2'b10: nx = up ? 2'b11 : 2'b00;
         2'b11: nx = up ? 2'b01 : 2'b10;
         default: nx = up ? 2'b00 : 2'b11;
      endcase
      set_ab(ax, nx);
      exp_pos[ax]  = up ? exp_pos[ax] + 1'b1 : exp_pos[ax] - 1'b1;
      exp_word[ax] = {exp_pos[ax][15:0], exp_ts};
   endtask

   task automatic check_axis(input string req, input int ax);
      logic [31:0] v;
      read(ax, 2'b00, v); check(req, $sformatf("axis%0d word", ax), v, exp_word[ax]);
      read(ax, 2'b01, v); check(req, $sformatf("axis%0d pos", ax), v, {8'h00, exp_pos[ax]});
      read(ax, 2'b10, v); check(req, $sformatf("axis%0d err", ax), v, {31'd0, exp_err[ax]});
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int i = 0; i < NA; i++) check_axis("R1", i);
      read(0, 2'b11, v); check("R9", "unused view", v, 32'd0);
   endtask

   task automatic t_up();
      ticks(7);
      for (int k = 0; k < 5; k++) step(0, 1'b1);
      strobe();
      check_axis("R2", 0);
      check_axis("R6", 0);
   endtask

   task automatic t_down();
      for (int k = 0; k < 3; k++) step(1, 1'b0);
      strobe();
      check_axis("R3", 1);
      check_axis("R9", 1);
   endtask

   task automatic t_last();
      ticks(4);
      step(2, 1'b1);
      ticks(6);
      step(2, 1'b1);
      strobe();
      check_axis("R7", 2);
   endtask

   task automatic t_bad();
      set_ab(3, 2'b11);
      exp_err[3] = 1'b1;
      strobe();
      check_axis("R4", 3);
      ticks(2);
      step(3, 1'b1);
      strobe();
      check_axis("R4", 3);
   endtask

   task automatic t_snapshot();
      logic [31:0] old_word, v;
      strobe();
      old_word = exp_word[0];
      step(0, 1'b1);
      step(0, 1'b1);
      read(0, 2'b00, v); check("R8", "word held before strobe", v, old_word);
      strobe();
      check_axis("R8", 0);
      for (int i = 1; i < NA; i++) check_axis("R10", i);
   endtask

   task automatic t_wrap();
      ticks(65536 + 3);
      step(2, 1'b0);
      strobe();
      check_axis("R5", 2);
   endtask

   initial begin
      exp_ts = '0;
      for (int i = 0; i < NA; i++) begin
         exp_pos[i] = '0; exp_word[i] = '0; exp_err[i] = 1'b0; ab_now[i] = 2'b00;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      t_reset();
      t_up();
      t_down();
      t_last();
      t_bad();
      t_snapshot();
      t_wrap();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (190000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule